// File: doc/BRIEF.md
# DRAM Command Spacing Checker

The block sits beside a DRAM command bus and judges every command as it goes by. One command arrives per clock, carrying a bank group and a bank address. The block keeps just enough history to tell whether the command came too soon after an earlier one under the device's minimum spacing rules. Those rules cover row activations to the same and to different bank groups, the rolling limit of four activations, column accesses to the same and to different groups, refresh entry with all banks closed, refresh recovery, and mode-register spacing. Every limit is a cycle count on an input port, so firmware or a test harness can change the limits at run time. The block never stalls or reorders traffic. It reports a one-cycle violation pulse together with a code that names the broken rule.

Internally a small phase state machine follows the device through refresh and mode-register settling. It has three states: `PH_READY`, `PH_REF_RECOVER` and `PH_MRS_SETTLE`. A refresh command moves it from any state into `PH_REF_RECOVER`. A mode-register command moves it from any state into `PH_MRS_SETTLE`. The timer returns it to `PH_READY` once the elapsed count reaches the refresh recovery limit, or in the settle state once it reaches both mode-register limits. The most recent of those two events owns the timer. Alongside the state machine sit several blocks. Per-group elapsed counters check row and column spacing. Per-bank open and precharge tracking decides whether a refresh is legal. A four-entry ring of timestamps enforces the activation window.

Top module: `dram_cmd_guard`

## Requirements
- R1: `cmd_i` is encoded as DES=0, NOP=1, ACT=2, RD=3, WR=4, PRE=5, REF=6, MRS=7. The verdict for a command sampled on clock edge k appears on `viol_o`/`rule_o` after edge k and holds for exactly one cycle. DES and NOP are never flagged. Reset clears both outputs. `rule_o` is 0 whenever `viol_o` is low.
- R2: The gap is the difference between the issue cycles of two commands. An ACT whose gap to the latest ACT in any other bank group is less than `t_rrd_s` is flagged with code 4.
- R3: An ACT whose gap to the latest ACT in its own bank group is less than `t_rrd_l` is flagged with code 5.
- R4: An ACT issued while four earlier ACTs all lie fewer than `t_faw` cycles back is flagged with code 6. A fifth ACT at a gap of exactly `t_faw` from the oldest of the four is legal.
- R5: A RD or WR whose gap to the latest RD/WR in another group is less than `t_ccd_s`, or to the latest RD/WR in its own group is less than `t_ccd_l`, is flagged with code 7. RD and WR share this history.
- R6: A REF is flagged with code 3 when any bank is open, or when any bank was closed by PRE fewer than `t_rp` cycles earlier. A PRE to a bank that is already closed does not restart that bank's precharge timer.
- R7: After a REF, any ACT, RD, WR, PRE, REF or MRS with a gap less than `t_rfc` is flagged with code 1.
- R8: An MRS with a gap to the previous MRS of less than `t_mrd` is flagged with code 2. An ACT, RD, WR, PRE or REF with a gap to the previous MRS of less than `t_mod` is also flagged with code 2.
- R9: When a command breaks several rules, the smallest nonzero code is reported.
- R10: A flagged command still updates all history (bank state, timestamps, phase) exactly as a legal one would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code for this cycle |
| bg_i | input | 2 | Bank group of the command |
| ba_i | input | 2 | Bank within the group |
| t_rrd_s | input | 8 | Minimum ACT gap, different groups |
| t_rrd_l | input | 8 | Minimum ACT gap, same group |
| t_faw | input | 8 | Four-activation window length |
| t_ccd_s | input | 8 | Minimum column gap, different groups |
| t_ccd_l | input | 8 | Minimum column gap, same group |
| t_rp | input | 8 | Precharge-to-refresh minimum |
| t_rfc | input | 8 | Refresh recovery time |
| t_mrd | input | 8 | MRS-to-MRS minimum |
| t_mod | input | 8 | MRS-to-other-command minimum |
| viol_o | output | 1 | One-cycle violation pulse |
| rule_o | output | 3 | Code of the broken rule |

## Verification
The bench sweeps the gap across every spacing rule, from one cycle up to past the limit. This catches an off-by-one that flags the gap equal to the limit, or one that lets the gap just below it through. A fifth activation is placed on both sides of the window edge, which exposes a history ring that evicts the wrong entry or compares ages with the wrong sign. Refresh is tried with a bank left open, just after a real precharge, and after a redundant precharge to a closed bank. A design that ignored open banks, or that restarted timers on a redundant PRE, would give the wrong verdict in one of these cases. Further cases check the priority between overlapping rules and confirm that a rejected activation still counts as history. A design that dropped illegal commands from history would pass a later activation it should flag.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    typedef enum logic [2:0] {
        CMD_DES = 3'd0,
        CMD_NOP = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_PRE = 3'd5,
        CMD_REF = 3'd6,
        CMD_MRS = 3'd7
    } cmd_e;

    // Lower code wins when several rules break at once.
    typedef enum logic [2:0] {
        RULE_NONE   = 3'd0,
        RULE_RFC    = 3'd1,
        RULE_MODE   = 3'd2,
        RULE_REFPRE = 3'd3,
        RULE_RRD_S  = 3'd4,
        RULE_RRD_L  = 3'd5,
        RULE_FAW    = 3'd6,
        RULE_CCD    = 3'd7
    } rule_e;

    typedef enum logic [1:0] {
        PH_READY       = 2'd0,
        PH_REF_RECOVER = 2'd1,
        PH_MRS_SETTLE  = 2'd2
    } phase_e;

endpackage

// File: rtl/dcg_phase_fsm.sv
module dcg_phase_fsm
    import dcg_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_e          cmd_i,
    input  logic [TW-1:0] t_rfc_i,
    input  logic [TW-1:0] t_mrd_i,
    input  logic [TW-1:0] t_mod_i,
    output logic          rfc_v_o,
    output logic          mode_v_o
);
    localparam logic [TW-1:0] SAT = '1;

    phase_e        state_q, state_d;
    logic [TW-1:0] cnt_q;
    logic          real_cmd;
    logic          evt;

    assign real_cmd = (cmd_i != CMD_DES) && (cmd_i != CMD_NOP);
    assign evt      = (cmd_i == CMD_REF) || (cmd_i == CMD_MRS);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_READY;
        else        state_q <= state_d;
    end

    // elapsed cycles since the latest REF or MRS
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= SAT;
        else if (evt)        cnt_q <= TW'(1);
        else if (cnt_q != SAT) cnt_q <= cnt_q + TW'(1);
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (cmd_i == CMD_REF) begin
            state_d = PH_REF_RECOVER;
        end else if (cmd_i == CMD_MRS) begin
            state_d = PH_MRS_SETTLE;
        end else begin
            unique case (state_q)
                PH_READY:       state_d = PH_READY;
                PH_REF_RECOVER: if (cnt_q >= t_rfc_i) state_d = PH_READY;
                PH_MRS_SETTLE:  if (cnt_q >= t_mrd_i && cnt_q >= t_mod_i) state_d = PH_READY;
                default:        state_d = PH_READY;
            endcase
        end
    end

    // outputs
    always_comb begin
        rfc_v_o  = 1'b0;
        mode_v_o = 1'b0;
        unique case (state_q)
            PH_READY: ;
            PH_REF_RECOVER: rfc_v_o = real_cmd && (cnt_q < t_rfc_i);
            PH_MRS_SETTLE: begin
                if (cmd_i == CMD_MRS) mode_v_o = cnt_q < t_mrd_i;
                else if (real_cmd)    mode_v_o = cnt_q < t_mod_i;
            end
            default: ;
        endcase
    end

    p_ref_enters_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_REF) |=> (state_q == PH_REF_RECOVER));

    p_mrs_enters_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_MRS) |=> (state_q == PH_MRS_SETTLE));

endmodule

// File: rtl/dcg_group_spacing.sv
module dcg_group_spacing #(
    parameter int NG = 4,
    parameter int TW = 8,
    localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic [GW-1:0] grp_i,
    input  logic [TW-1:0] lim_short_i,
    input  logic [TW-1:0] lim_long_i,
    output logic          short_o,
    output logic          long_o
);
    localparam logic [TW-1:0] SAT = '1;

    logic [TW-1:0] since_q [NG];
    logic [NG-1:0] near_other;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n)                           since_q[g] <= SAT;
            else if (hit_i && grp_i == GW'(g))    since_q[g] <= TW'(1);
            else if (since_q[g] != SAT)           since_q[g] <= since_q[g] + TW'(1);
        end
        assign near_other[g] = (grp_i != GW'(g)) && (since_q[g] < lim_short_i);
    end

    assign short_o = hit_i && (|near_other);
    assign long_o  = hit_i && (since_q[grp_i] < lim_long_i);

    p_fresh_group_is_near_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && lim_long_i > TW'(1)) |=> (since_q[$past(grp_i)] < lim_long_i));

endmodule

// File: rtl/dcg_bank_state.sv
module dcg_bank_state
    import dcg_pkg::*;
#(
    parameter int NB = 16,
    parameter int TW = 8,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_e          cmd_i,
    input  logic [BW-1:0] bank_i,
    input  logic [TW-1:0] t_rp_i,
    output logic          idle_ok_o
);
    localparam logic [TW-1:0] SAT = '1;

    logic          open_q  [NB];
    logic [TW-1:0] since_q [NB];
    logic [NB-1:0] settled;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b]  <= 1'b0;
                since_q[b] <= SAT;
            end else if (cmd_i == CMD_ACT && bank_i == BW'(b)) begin
                open_q[b]  <= 1'b1;
            end else if (cmd_i == CMD_PRE && bank_i == BW'(b) && open_q[b]) begin
                open_q[b]  <= 1'b0;
                since_q[b] <= TW'(1);
            end else if (since_q[b] != SAT) begin
                since_q[b] <= since_q[b] + TW'(1);
            end
        end
        assign settled[b] = !open_q[b] && (since_q[b] >= t_rp_i);
    end

    assign idle_ok_o = &settled;

    p_act_blocks_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT) |=> !idle_ok_o);

endmodule

// File: rtl/dcg_act_window.sv
module dcg_act_window #(
    parameter int DEPTH = 4,
    parameter int SW    = 16,
    parameter int TW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic [TW-1:0] t_faw_i,
    output logic          faw_v_o
);
    logic [SW-1:0]    now_q;
    logic [SW-1:0]    stamp_q [DEPTH];
    logic             vld_q   [DEPTH];
    logic [SW-1:0]    age     [DEPTH];
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] vld_vec;
    logic [PW-1:0]    ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + SW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (act_i) ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        assign age[k]     = now_q - stamp_q[k];
        assign live[k]    = vld_q[k] && (age[k] < SW'(t_faw_i));
        assign vld_vec[k] = vld_q[k];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[k]   <= 1'b0;
                stamp_q[k] <= '0;
            end else if (act_i && ptr_q == PW'(k)) begin
                vld_q[k]   <= 1'b1;
                stamp_q[k] <= now_q;
            end else begin
                vld_q[k]   <= live[k];
            end
        end
    end

    assign faw_v_o = act_i && (&live);

    p_faw_logs_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> (vld_vec != '0));

endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard
    import dcg_pkg::*;
#(
    parameter int NBG       = 4,
    parameter int NBPG      = 4,
    parameter int TW        = 8,
    parameter int STAMP_W   = 16,
    parameter int FAW_DEPTH = 4,
    localparam int BGW      = $clog2(NBG),
    localparam int BAW      = $clog2(NBPG),
    localparam int NB       = NBG * NBPG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     cmd_i,
    input  logic [BGW-1:0] bg_i,
    input  logic [BAW-1:0] ba_i,
    input  logic [TW-1:0]  t_rrd_s,
    input  logic [TW-1:0]  t_rrd_l,
    input  logic [TW-1:0]  t_faw,
    input  logic [TW-1:0]  t_ccd_s,
    input  logic [TW-1:0]  t_ccd_l,
    input  logic [TW-1:0]  t_rp,
    input  logic [TW-1:0]  t_rfc,
    input  logic [TW-1:0]  t_mrd,
    input  logic [TW-1:0]  t_mod,
    output logic           viol_o,
    output logic [2:0]     rule_o
);
    cmd_e  cmd;
    rule_e code;
    logic  is_act, is_col;
    logic  rfc_v, mode_v, idle_ok;
    logic  rrd_s_v, rrd_l_v, ccd_s_v, ccd_l_v, faw_v;
    logic  viol_q;
    rule_e rule_q;

    assign cmd    = cmd_e'(cmd_i);
    assign is_act = (cmd == CMD_ACT);
    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

    dcg_phase_fsm #(.TW(TW)) u_phase (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd),
        .t_rfc_i(t_rfc), .t_mrd_i(t_mrd), .t_mod_i(t_mod),
        .rfc_v_o(rfc_v), .mode_v_o(mode_v)
    );

    dcg_bank_state #(.NB(NB), .TW(TW)) u_banks (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd),
        .bank_i({bg_i, ba_i}), .t_rp_i(t_rp), .idle_ok_o(idle_ok)
    );

    dcg_group_spacing #(.NG(NBG), .TW(TW)) u_row (
        .clk(clk), .rst_n(rst_n), .hit_i(is_act), .grp_i(bg_i),
        .lim_short_i(t_rrd_s), .lim_long_i(t_rrd_l),
        .short_o(rrd_s_v), .long_o(rrd_l_v)
    );

    dcg_group_spacing #(.NG(NBG), .TW(TW)) u_col (
        .clk(clk), .rst_n(rst_n), .hit_i(is_col), .grp_i(bg_i),
        .lim_short_i(t_ccd_s), .lim_long_i(t_ccd_l),
        .short_o(ccd_s_v), .long_o(ccd_l_v)
    );

    dcg_act_window #(.DEPTH(FAW_DEPTH), .SW(STAMP_W), .TW(TW)) u_faw (
        .clk(clk), .rst_n(rst_n), .act_i(is_act), .t_faw_i(t_faw),
        .faw_v_o(faw_v)
    );

    always_comb begin
        if (rfc_v)                             code = RULE_RFC;
        else if (mode_v)                       code = RULE_MODE;
        else if (cmd == CMD_REF && !idle_ok)   code = RULE_REFPRE;
        else if (rrd_s_v)                      code = RULE_RRD_S;
        else if (rrd_l_v)                      code = RULE_RRD_L;
        else if (faw_v)                        code = RULE_FAW;
        else if (ccd_s_v || ccd_l_v)           code = RULE_CCD;
        else                                   code = RULE_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
            rule_q <= RULE_NONE;
        end else begin
            viol_q <= (code != RULE_NONE);
            rule_q <= code;
        end
    end

    assign viol_o = viol_q;
    assign rule_o = rule_q;

    p_quiet_on_idle_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> ($past(cmd_i) != 3'd0 && $past(cmd_i) != 3'd1));

    p_code_with_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o == (rule_o != 3'd0));

endmodule

// File: tb/dram_cmd_guard_test.sv
`timescale 1ns/1ps
module dram_cmd_guard_test;
    localparam int S = 2, L = 5, FAW = 12, CS = 2, CL = 4;
    localparam int RP = 4, RFC = 9, MRD = 3, MOD = 6;
    localparam logic [2:0] DES = 0, NOP = 1, ACT = 2, RD = 3, WR = 4, PRE = 5, REF = 6, MRS = 7;

    logic       clk = 0, rst_n = 0;
    logic [2:0] cmd = DES;
    logic [1:0] bg = 0, ba = 0;
    logic       viol;
    logic [2:0] rule;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    dram_cmd_guard uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bg_i(bg), .ba_i(ba),
        .t_rrd_s(8'(S)), .t_rrd_l(8'(L)), .t_faw(8'(FAW)),
        .t_ccd_s(8'(CS)), .t_ccd_l(8'(CL)), .t_rp(8'(RP)),
        .t_rfc(8'(RFC)), .t_mrd(8'(MRD)), .t_mod(8'(MOD)),
        .viol_o(viol), .rule_o(rule)
    );

    task automatic check(input logic [2:0] exp, input string req);
        total++;
        if (viol !== (exp != 0) || rule !== exp) begin
            bad++;
            $display("FAIL %s: got viol=%0b rule=%0d, expected viol=%0b rule=%0d",
                     req, viol, rule, (exp != 0), exp);
        end
    endtask

    // drive at a falling edge, verdict is visible at the next falling edge
    task automatic step(input logic [2:0] c, input int g, input int b,
                        input bit chk, input logic [2:0] exp, input string req);
        cmd = c; bg = 2'(g); ba = 2'(b);
        @(negedge clk);
        if (chk) check(exp, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(DES, 0, 0, 0, 0, "");
    endtask

    task automatic close_all();
        for (int b = 0; b < 16; b++) step(PRE, b / 4, b % 4, 0, 0, "");
        idle(40);
    endtask

    task automatic pair(input logic [2:0] c1, input int g1, input int b1,
                        input logic [2:0] c2, input int g2, input int b2,
                        input int gap, input int lim, input logic [2:0] code,
                        input string req);
        step(c1, g1, b1, 1, 0, req);
        idle(gap - 1);
        step(c2, g2, b2, 1, (gap < lim) ? code : 3'd0, req);
        idle(40);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(0, "R1 reset");
        rst_n = 1;
        idle(5);
        check(0, "R1 idle after reset");

        for (int g = 1; g <= 4; g++) pair(ACT, 0, 0, ACT, 1, 0, g, S, 4, "R2 rrd_s");
        for (int g = 1; g <= 7; g++) pair(ACT, 2, 0, ACT, 2, 1, g, L, 5, "R3 rrd_l");

        // R4: four ACTs 2 apart, fifth at offset t from the first
        for (int t = 8; t <= 13; t++) begin
            step(ACT, 0, 0, 1, 0, "R4 setup"); idle(1);
            step(ACT, 1, 0, 1, 0, "R4 setup"); idle(1);
            step(ACT, 2, 0, 1, 0, "R4 setup"); idle(1);
            step(ACT, 3, 0, 1, 0, "R4 setup");
            idle(t - 7);
            step(ACT, 0, 1, 1, (t < FAW) ? 3'd6 : 3'd0, "R4 faw");
            idle(40);
        end

        for (int g = 1; g <= 4; g++) pair(RD, 0, 0, WR, 1, 0, g, CS, 7, "R5 ccd_s");
        for (int g = 1; g <= 6; g++) pair(RD, 3, 0, RD, 3, 2, g, CL, 7, "R5 ccd_l");
        for (int g = 1; g <= 5; g++) pair(MRS, 0, 0, MRS, 0, 0, g, MRD, 2, "R8 mrd");
        for (int g = 1; g <= 8; g++) pair(MRS, 0, 0, RD, 0, 0, g, MOD, 2, "R8 mod");

        close_all();
        for (int g = 1; g <= 11; g++) pair(REF, 0, 0, RD, 0, 0, g, RFC, 1, "R7 rfc");

        step(REF, 0, 0, 1, 0, "R1 ref");
        step(NOP, 0, 0, 1, 0, "R1 nop in recovery");
        idle(40);

        for (int g = 1; g <= 6; g++) begin
            step(ACT, 1, 2, 1, 0, "R6 setup");
            idle(10);
            step(PRE, 1, 2, 1, 0, "R6 setup");
            idle(g - 1);
            step(REF, 0, 0, 1, (g < RP) ? 3'd3 : 3'd0, "R6 trp");
            idle(40);
        end

        step(ACT, 0, 1, 1, 0, "R6 setup");
        idle(10);
        step(REF, 0, 0, 1, 3, "R6 open bank");
        step(REF, 0, 0, 1, 1, "R9 rfc over open bank");
        idle(40);
        close_all();

        step(PRE, 3, 3, 1, 0, "R6 setup");
        step(REF, 0, 0, 1, 0, "R6 pre on closed bank ignored");
        idle(40);

        step(ACT, 2, 2, 1, 0, "R10 setup");
        step(ACT, 2, 3, 1, 5, "R10 first illegal");
        idle(3);
        step(ACT, 2, 0, 1, 5, "R10 illegal act kept as history");
        idle(10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule